// File: doc/BRIEF.md
# Identification Page Write Controller

This block is the serial command engine that programs a 128-byte identification page in an EEPROM-style device. It watches a mode-0 SPI slave interface and picks out one command: an 8-bit opcode, a 16-bit address and one or more data bytes. It collects the data into a staging area, following the in-page wrap rule. When chip select returns high it decides whether the command may run. If it may, the staged bytes are copied into the page and a self-timed write cycle begins.

The serial pins are brought into the system clock domain through synchronizers, so the SPI clock must be slow compared with the system clock. The Write Enable Latch is set by a one-cycle request from the rest of the device. Block-protect and lock status arrive as levels. The page contents can be read through a combinational read port.

Top module: `idpage_write_ctrl`

## Requirements
- R1: After reset, `wip` and `wel` are 0 and every page byte reads 8'hFF.
- R2: A high `wel_set` sampled at a clock edge sets `wel`. If a clearing event (a rejected command or the end of a write cycle) happens at the same edge, the clear wins and `wel` reads 0.
- R3: Bits are sampled most significant bit first, on rising `spi_sck` while `spi_cs_n` is low. The frame is opcode 8'h82, then address high byte, then address low byte, then data bytes. An accepted command writes its data bytes to page offsets addr[6:0], addr[6:0]+1 and so on. Address bits [15:11] and [9:7] have no effect.
- R4: Offsets advance modulo 128. When a command wraps past offset 127 it continues at offset 0, and the last byte sent to an offset is the one kept.
- R5: The decision is taken at the third rising `clk` edge after the first edge that samples `spi_cs_n` high. On acceptance `wip` is 1 for exactly TW_CYCLES clocks. At the edge where `wip` returns to 0, `wel` is cleared.
- R6: A well-formed command is rejected if any of the following holds at the decision edge: `wel` is 0, `bp_in` is 2'b11, `wip` is 1, or `lock_in` is 1. A rejected command writes nothing, leaves `wip` at 0 and clears `wel` at the decision edge.
- R7: A command is also rejected, with the same effects as in R6, if at least one data byte completed but chip select rose partway through a later byte (the bit count is not a multiple of 8).
- R8: A frame is ignored and changes no state (`wel` keeps its value) if its opcode is not 8'h82, if address bit 10 is 1, or if no data byte was completed.
- R9: Page bytes change only at the decision edge of an accepted command. Offsets that the command did not address keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sck | input | 1 | Serial clock, mode 0 |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data in |
| wel_set | input | 1 | One-cycle request that sets the Write Enable Latch |
| bp_in | input | 2 | Block-protect status bits |
| lock_in | input | 1 | Identification page locked |
| rd_addr | input | 7 | Page read offset |
| wip | output | 1 | Write cycle in progress |
| wel | output | 1 | Write Enable Latch |
| rd_data | output | 8 | Page byte at `rd_addr` |

## Verification
Two functions can land on the same clock edge: setting the Write Enable Latch from `wel_set`, and clearing it, either because a command is rejected or because a write cycle ends. The bench places a `wel_set` pulse exactly on the decision edge of a command that block protection rejects. It places another pulse on the edge where its own model counts the write timer to zero. In both cases the latch must read 0 afterwards. A cycle-by-cycle model in the bench predicts `wip` and `wel` on every clock and a page image for every read-back, so any disagreement in these collisions is reported at the cycle where it appears.

// File: rtl/idpw_pkg.sv
// Shared constants and types for the identification page write controller.
// Assumes an 8-bit serial byte and a 16-bit address field.
package idpw_pkg;
    localparam int          BYTE_W       = 8;
    localparam logic [7:0]  OPC_WR_IDPG  = 8'h82;
    localparam int          SEL_BIT_HI   = 2;   // address bit 10 as bit 2 of the high byte

    typedef enum logic [1:0] {
        PH_OPC  = 2'd0,
        PH_ADH  = 2'd1,
        PH_ADL  = 2'd2,
        PH_DATA = 2'd3
    } phase_t;

    typedef struct packed {
        logic [7:0] opcode;
        logic       addr_sel;     // address bit 10
        logic       data_seen;    // at least one complete data byte
        logic       on_boundary;  // bit count is a multiple of 8
    } frame_info_t;
endpackage

// File: rtl/idpw_sync.sv
// Multi-bit synchronizer with edge detection.
// Each input bit passes through STAGES flops. One more flop yields rise and fall pulses.
// Assumes the inputs change slowly compared with clk.
module idpw_sync #(
    parameter int             N       = 3,
    parameter int             STAGES  = 2,
    parameter logic [N-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] din,
    output logic [N-1:0] lvl,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    logic [N-1:0] prev_q;

    genvar s;
    for (s = 0; s < STAGES; s++) begin : g_stg
        logic [N-1:0] q;
        if (s == 0) begin : g_first
            // first stage samples the raw pins
            always_ff @(posedge clk) begin
                if (!rst_n) q <= RST_VAL;
                else        q <= din;
            end
        end else begin : g_next
            // later stages shift the previous stage along
            always_ff @(posedge clk) begin
                if (!rst_n) q <= RST_VAL;
                else        q <= g_stg[s-1].q;
            end
        end
    end

    assign lvl = g_stg[STAGES-1].q;

    // remember last synchronized level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= RST_VAL;
        else        prev_q <= lvl;
    end

    assign rise = lvl & ~prev_q;
    assign fall = ~lvl & prev_q;
endmodule

// File: rtl/idpw_deser.sv
// Frame deserializer. It shifts serial bits into bytes and tracks the frame phase.
// It keeps the opcode and address bit 10, and issues one byte strobe per completed byte.
// Assumes frame_start, sck_rise and cs_active come from one synchronizer.
module idpw_deser import idpw_pkg::*; (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              cs_active,
    input  logic              sck_rise,
    input  logic              mosi,
    output logic              byte_stb,
    output logic [BYTE_W-1:0] byte_data,
    output phase_t            byte_phase,
    output frame_info_t       info
);
    logic [2:0]        bit_idx;
    logic [BYTE_W-2:0] shift_q;
    phase_t            phase_q;
    logic [7:0]        opcode_q;
    logic              sel_q;
    logic              seen_q;

    logic [BYTE_W-1:0] assembled;
    assign assembled = {shift_q, mosi};

    // shift bits, close bytes and advance the phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_idx    <= '0;
            shift_q    <= '0;
            phase_q    <= PH_OPC;
            opcode_q   <= '0;
            sel_q      <= 1'b0;
            seen_q     <= 1'b0;
            byte_stb   <= 1'b0;
            byte_data  <= '0;
            byte_phase <= PH_OPC;
        end else begin
            byte_stb <= 1'b0;
            if (frame_start) begin
                bit_idx  <= '0;
                shift_q  <= '0;
                phase_q  <= PH_OPC;
                opcode_q <= '0;
                sel_q    <= 1'b0;
                seen_q   <= 1'b0;
            end else if (sck_rise && cs_active) begin
                shift_q <= assembled[BYTE_W-2:0];
                bit_idx <= bit_idx + 3'd1;
                if (bit_idx == 3'd7) begin
                    byte_stb   <= 1'b1;
                    byte_data  <= assembled;
                    byte_phase <= phase_q;
                    case (phase_q)
                        PH_OPC: begin
                            opcode_q <= assembled;
                            phase_q  <= PH_ADH;
                        end
                        PH_ADH: begin
                            sel_q   <= assembled[SEL_BIT_HI];
                            phase_q <= PH_ADL;
                        end
                        PH_ADL: phase_q <= PH_DATA;
                        default: seen_q <= 1'b1;
                    endcase
                end
            end
        end
    end

    assign info.opcode      = opcode_q;
    assign info.addr_sel    = sel_q;
    assign info.data_seen   = seen_q;
    assign info.on_boundary = (bit_idx == 3'd0);
endmodule

// File: rtl/idpw_store.sv
// Staging buffer and page array.
// Data bytes land in the staging entry picked by a wrapping offset and mark that entry.
// On commit, every marked entry is copied into the page in one clock.
// Assumes commit never coincides with a byte strobe.
module idpw_store import idpw_pkg::*; #(
    parameter int                PAGE_BYTES = 128,
    parameter logic [BYTE_W-1:0] ERASE_VAL  = 8'hFF,
    localparam int               ADDR_W     = $clog2(PAGE_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              byte_stb,
    input  logic [BYTE_W-1:0] byte_data,
    input  phase_t            byte_phase,
    input  logic              commit,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BYTE_W-1:0] rd_data
);
    logic [BYTE_W-1:0]     stage_q [PAGE_BYTES];
    logic [BYTE_W-1:0]     page_q  [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] mark_q;
    logic [ADDR_W-1:0]     off_q;
    logic                  data_wr;

    assign data_wr = byte_stb && (byte_phase == PH_DATA);

    // load the start offset from the address low byte, then step it on each data byte
    always_ff @(posedge clk) begin
        if (!rst_n)                                        off_q <= '0;
        else if (byte_stb && byte_phase == PH_ADL)         off_q <= byte_data[ADDR_W-1:0];
        else if (data_wr)                                  off_q <= off_q + 1'b1;
    end

    // capture data bytes into staging and mark them; clear marks at frame start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mark_q <= '0;
            for (int i = 0; i < PAGE_BYTES; i++) stage_q[i] <= '0;
        end else if (frame_start) begin
            mark_q <= '0;
        end else if (data_wr) begin
            for (int i = 0; i < PAGE_BYTES; i++) begin
                if (off_q == ADDR_W'(i)) begin
                    stage_q[i] <= byte_data;
                    mark_q[i]  <= 1'b1;
                end
            end
        end
    end

    // copy marked staging entries into the page on commit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < PAGE_BYTES; i++) page_q[i] <= ERASE_VAL;
        end else if (commit) begin
            for (int i = 0; i < PAGE_BYTES; i++) begin
                if (mark_q[i]) page_q[i] <= stage_q[i];
            end
        end
    end

    assign rd_data = page_q[rd_addr];
endmodule

// File: rtl/idpw_ctrl.sv
// Command decision and write timer.
// At frame end it classifies the frame as ignored, rejected or accepted.
// Accepted frames start a TW_CYCLES write cycle; rejected ones clear the enable latch.
// Assumes frame_end is a single-cycle pulse.
module idpw_ctrl import idpw_pkg::*; #(
    parameter int  TW_CYCLES = 1000,
    localparam int CNT_W     = $clog2(TW_CYCLES + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        frame_end,
    input  frame_info_t info,
    input  logic        wel_set,
    input  logic [1:0]  bp_in,
    input  logic        lock_in,
    output logic        wip,
    output logic        wel,
    output logic        commit
);
    logic [CNT_W-1:0] cnt_q;
    logic             well_formed;
    logic             guards_ok;
    logic             reject;
    logic             done;

    assign well_formed = (info.opcode == OPC_WR_IDPG) && !info.addr_sel && info.data_seen;
    assign guards_ok   = info.on_boundary && wel && (bp_in != 2'b11) && !wip && !lock_in;
    assign commit      = frame_end && well_formed && guards_ok;
    assign reject      = frame_end && well_formed && !guards_ok;
    assign done        = wip && (cnt_q == '0);

    // run the self-timed write cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wip   <= 1'b0;
            cnt_q <= '0;
        end else if (commit) begin
            wip   <= 1'b1;
            cnt_q <= CNT_W'(TW_CYCLES - 1);
        end else if (done) begin
            wip   <= 1'b0;
        end else if (wip) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // enable latch: clearing beats setting
    always_ff @(posedge clk) begin
        if (!rst_n)              wel <= 1'b0;
        else if (done || reject) wel <= 1'b0;
        else if (wel_set)        wel <= 1'b1;
    end
endmodule

// File: rtl/idpage_write_ctrl.sv
// Top of the identification page write controller.
// Synchronizes the serial pins, deserializes the frame, stages the data and decides at chip-select rise.
// Assumes spi_sck is slow enough that each level spans several clk cycles.
module idpage_write_ctrl import idpw_pkg::*; #(
    parameter int                PAGE_BYTES  = 128,
    parameter int                TW_CYCLES   = 1000,
    parameter int                SYNC_STAGES = 2,
    parameter logic [BYTE_W-1:0] ERASE_VAL   = 8'hFF,
    localparam int               ADDR_W      = $clog2(PAGE_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sck,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    input  logic              wel_set,
    input  logic [1:0]        bp_in,
    input  logic              lock_in,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              wip,
    output logic              wel,
    output logic [BYTE_W-1:0] rd_data
);
    logic [2:0]        s_lvl, s_rise, s_fall;
    logic              cs_rise, cs_fall, cs_active, sck_rise, mosi_s;
    logic              byte_stb;
    logic [BYTE_W-1:0] byte_data;
    phase_t            byte_phase;
    frame_info_t       info;
    logic              commit;
    logic              unused_sync_bits;

    idpw_sync #(.N(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({spi_cs_n, spi_sck, spi_mosi}),
        .lvl  (s_lvl),
        .rise (s_rise),
        .fall (s_fall)
    );

    assign cs_rise   = s_rise[2];
    assign cs_fall   = s_fall[2];
    assign cs_active = !s_lvl[2];
    assign sck_rise  = s_rise[1];
    assign mosi_s    = s_lvl[0];
    assign unused_sync_bits = ^{s_lvl[1], s_rise[0], s_fall[1:0]};

    idpw_deser u_deser (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_start(cs_fall),
        .cs_active  (cs_active),
        .sck_rise   (sck_rise),
        .mosi       (mosi_s),
        .byte_stb   (byte_stb),
        .byte_data  (byte_data),
        .byte_phase (byte_phase),
        .info       (info)
    );

    idpw_store #(.PAGE_BYTES(PAGE_BYTES), .ERASE_VAL(ERASE_VAL)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_start(cs_fall),
        .byte_stb   (byte_stb),
        .byte_data  (byte_data),
        .byte_phase (byte_phase),
        .commit     (commit),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data)
    );

    idpw_ctrl #(.TW_CYCLES(TW_CYCLES)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .frame_end(cs_rise),
        .info     (info),
        .wel_set  (wel_set),
        .bp_in    (bp_in),
        .lock_in  (lock_in),
        .wip      (wip),
        .wel      (wel),
        .commit   (commit)
    );
endmodule

// File: rtl/idpw_chk.sv
// Property checker for the identification page write controller, bound to the top.
module idpw_chk #(
    parameter int TW_CYCLES = 1000,
    parameter int ADDR_W    = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wip,
    input logic              wel,
    input logic              wel_set,
    input logic              frame_end,
    input logic [1:0]        bp_in,
    input logic              lock_in,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [7:0]        rd_data
);
    int hi_cnt;

    // count clocks spent with wip high
    always_ff @(posedge clk) begin
        if (!rst_n)   hi_cnt <= 0;
        else if (wip) hi_cnt <= hi_cnt + 1;
        else          hi_cnt <= 0;
    end

    // R5
    wip_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wip) |-> (hi_cnt == TW_CYCLES));

    // R5
    wip_end_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wip) |-> !wel);

    // R6
    wip_needs_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wip) |-> $past(wel));

    // R6
    wip_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wip) |-> (($past(bp_in) != 2'b11) && !$past(lock_in)));

    // R2
    wel_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wel_set && !wip && !frame_end) |=> wel);

    // R9
    page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$rose(wip) && $stable(rd_addr)) |-> $stable(rd_data));
endmodule

bind idpage_write_ctrl idpw_chk #(.TW_CYCLES(TW_CYCLES), .ADDR_W(ADDR_W)) u_idpw_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wip      (wip),
    .wel      (wel),
    .wel_set  (wel_set),
    .frame_end(cs_rise),
    .bp_in    (bp_in),
    .lock_in  (lock_in),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data)
);

// File: tb/test_idpage_write_ctrl.sv
module test_idpage_write_ctrl;
    localparam int TW = 400;
    localparam int PB = 128;

    logic       clk = 1'b0, rst_n = 1'b0;
    logic       sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic       wel_set = 1'b0, lock = 1'b0;
    logic [1:0] bp = 2'b00;
    logic [6:0] rd_addr = '0;
    logic       wip, wel;
    logic [7:0] rd_data;

    always #5 clk = ~clk;

    idpage_write_ctrl #(.TW_CYCLES(TW)) i_idpage_write_ctrl (
        .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
        .wel_set(wel_set), .bp_in(bp), .lock_in(lock), .rd_addr(rd_addr),
        .wip(wip), .wel(wel), .rd_data(rd_data)
    );

    int vecs = 0, errs = 0, cyc = 0;

    // reference model state
    bit         m_wip, m_wel, m_clr, m_wip_old, m_wel_old;
    int         m_cnt;
    bit [7:0]   m_page [PB];
    int         pend_edge = -1;
    bit         pend_wf, pend_bnd;
    int         pend_off;
    logic [7:0] pend_q[$];
    logic [7:0] q_data[$];

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        vecs++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // behavioural model stepped on every clock edge
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_wip = 0; m_wel = 0; m_cnt = 0;
            for (int i = 0; i < PB; i++) m_page[i] = 8'hFF;
        end else begin
            m_clr = 0; m_wip_old = m_wip; m_wel_old = m_wel;
            if (m_wip_old) begin
                m_cnt--;
                if (m_cnt == 0) begin m_wip = 0; m_clr = 1; end
            end
            if (cyc == pend_edge && pend_wf) begin
                if (!pend_bnd || !m_wel_old || bp == 2'b11 || m_wip_old || lock)
                    m_clr = 1;
                else begin
                    m_wip = 1; m_cnt = TW;
                    for (int i = 0; i < pend_q.size(); i++) m_page[(pend_off + i) % PB] = pend_q[i];
                end
            end
            if (m_clr) m_wel = 0;
            else if (wel_set) m_wel = 1;
        end
    end

    // compare status outputs every clock
    always @(negedge clk) begin
        if (rst_n) begin
            chk(wip === m_wip, "R5/R6 wip", int'(wip), int'(m_wip));
            chk(wel === m_wel, "R2 wel", int'(wel), int'(m_wel));
        end
    end

    task automatic check_page(input string req);
        for (int a = 0; a < PB; a++) begin
            @(negedge clk);
            rd_addr = 7'(a);
            #1;
            chk(rd_data === m_page[a], $sformatf("%s page[%0d]", req, a), int'(rd_data), int'(m_page[a]));
        end
    endtask

    task automatic send_bit(input logic b);
        mosi = b;
        repeat (3) @(negedge clk);
        sck = 1'b1;
        repeat (3) @(negedge clk);
        sck = 1'b0;
    endtask

    task automatic fill(input int n, input logic [7:0] seed);
        q_data.delete();
        for (int i = 0; i < n; i++) q_data.push_back(8'(seed + i * 7));
    endtask

    task automatic pulse_wel();
        @(negedge clk) wel_set = 1'b1;
        @(negedge clk) wel_set = 1'b0;
    endtask

    task automatic send_frame(input logic [7:0] opc, input logic [15:0] addr,
                              input int extra, input bit pulse_dec);
        logic [7:0] bytes[$];
        bytes = {opc, addr[15:8], addr[7:0]};
        foreach (q_data[i]) bytes.push_back(q_data[i]);
        @(negedge clk) cs_n = 1'b0;
        repeat (3) @(negedge clk);
        foreach (bytes[i]) for (int b = 7; b >= 0; b--) send_bit(bytes[i][b]);
        repeat (extra) send_bit(1'b1);
        repeat (3) @(negedge clk);
        cs_n      = 1'b1;
        pend_wf   = (opc == 8'h82) && !addr[10] && (q_data.size() > 0);
        pend_bnd  = (extra == 0);
        pend_off  = int'(addr[6:0]);
        pend_q    = q_data;
        pend_edge = cyc + 3;
        if (pulse_dec) begin
            repeat (2) @(negedge clk);
            wel_set = 1'b1;
            @(negedge clk) wel_set = 1'b0;
        end
        repeat (8) @(negedge clk);
    endtask

    task automatic wait_idle();
        while (wip || m_wip) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!wip && !wel, "R1 status after reset", int'({wip, wel}), 0);
        check_page("R1");

        // R6 no enable latch
        fill(2, 8'h10); send_frame(8'h82, 16'h0010, 0, 0);
        chk(wel == 1'b0, "R6 no WEL", int'(wel), 0);
        check_page("R6 no WEL");

        // R3 basic accept
        pulse_wel(); fill(3, 8'hA0); send_frame(8'h82, 16'h0005, 0, 0);
        chk(wip == 1'b1, "R5 busy after accept", int'(wip), 1);
        wait_idle();
        chk(wel == 1'b0, "R5 WEL cleared at end", int'(wel), 0);
        check_page("R3 basic");

        // R3 don't-care address bits
        pulse_wel(); fill(4, 8'h33); send_frame(8'h82, 16'hF8B0, 0, 0);
        wait_idle(); check_page("R3 ignored addr bits");

        // R4 wrap and overwrite
        pulse_wel(); fill(130, 8'h05); send_frame(8'h82, 16'h007E, 0, 0);
        wait_idle(); check_page("R4 wrap");

        // R6 block protect
        pulse_wel(); bp = 2'b11; fill(2, 8'hC1); send_frame(8'h82, 16'h0020, 0, 0);
        chk(wel == 1'b0, "R6 block protect", int'(wel), 0);
        bp = 2'b00; check_page("R6 bp");

        // R6 lock
        pulse_wel(); lock = 1'b1; send_frame(8'h82, 16'h0020, 0, 0);
        chk(wel == 1'b0, "R6 locked", int'(wel), 0);
        lock = 1'b0; check_page("R6 lock");

        // R6 busy reject, with bp=10 allowed
        bp = 2'b10;
        pulse_wel(); fill(2, 8'h11); send_frame(8'h82, 16'h0040, 0, 0);
        pulse_wel(); fill(2, 8'h99); send_frame(8'h82, 16'h0042, 0, 0);
        chk(wip == 1'b1 && wel == 1'b0, "R6 busy reject", int'({wip, wel}), 2);
        wait_idle(); bp = 2'b00; check_page("R6 busy");

        // R7 chip select off byte boundary
        pulse_wel(); fill(2, 8'h5A); send_frame(8'h82, 16'h0060, 3, 0);
        chk(wel == 1'b0, "R7 partial byte", int'(wel), 0);
        check_page("R7");

        // R8 ignored frames keep WEL
        pulse_wel(); fill(2, 8'h77);
        send_frame(8'h02, 16'h0070, 0, 0);
        chk(wel == 1'b1, "R8 wrong opcode", int'(wel), 1);
        send_frame(8'h82, 16'h0470, 0, 0);
        chk(wel == 1'b1, "R8 address bit 10", int'(wel), 1);
        q_data.delete();
        send_frame(8'h82, 16'h0070, 0, 0);
        chk(wel == 1'b1, "R8 no data byte", int'(wel), 1);
        send_frame(8'h82, 16'h0070, 5, 0);
        chk(wel == 1'b1, "R8 partial first data byte", int'(wel), 1);
        check_page("R8");

        // R2 set and reject-clear on the same edge
        bp = 2'b11; fill(1, 8'hE0); send_frame(8'h82, 16'h0001, 0, 1);
        chk(wel == 1'b0, "R2 clear beats set on reject", int'(wel), 0);
        bp = 2'b00;

        // R2 set and end-of-write clear on the same edge
        pulse_wel(); fill(2, 8'h4C); send_frame(8'h82, 16'h0050, 0, 0);
        while (!(m_wip && m_cnt == 1)) @(negedge clk);
        wel_set = 1'b1;
        @(negedge clk) wel_set = 1'b0;
        chk(wel == 1'b0, "R2 clear beats set at write end", int'(wel), 0);
        wait_idle(); check_page("R9 final image");

        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errs++;
        $display("FAIL R5 watchdog expired actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end
endmodule